// File: doc/BRIEF.md
# PWM Trip Protection Unit

This block sits between a PWM generator and the output pads. It overrides the two PWM channels (A and B) with a safe state when a fault is seen. A fault comes from an active-low trip input, or from a software force command. Each trip input can be routed into a one-shot group, a cycle-by-cycle group, both groups, or neither. The override takes effect in the same clock cycle as the fault, through a purely combinational path. The time base, compare logic, dead-band and input synchronisation are outside the block. The trip inputs are assumed to be synchronous to `clk` already.

The two groups clear in different ways. A one-shot trip holds the override and its flag until software issues a clear. A cycle-by-cycle trip releases the override by itself on the next counter-zero strobe once the fault has gone away. Its flag, however, stays set until software clears it. A global interrupt flag records that an enabled trip flag has gone from 0 to 1. This flag drives the interrupt output until software clears it.

Software reaches the block through a write-only port with four word addresses. Address 0 holds the one-shot routing mask, and address 1 holds the cycle-by-cycle routing mask. Address 2 holds the action codes and the interrupt enables. Address 3 is a command strobe that is never stored.

Top module: `pwm_trip_guard`

## Requirements
- R1: After reset, both routing masks are 0, both action codes are 11 and both interrupt enables are 0. The one-shot flag, the cycle-by-cycle flag and `irq` are 0. Each channel output follows its input, with its enable at 1.
- R2: Address 2 bits [1:0] hold the code for channel A and bits [3:2] hold the code for channel B. While any trip is active, the codes act as follows: 00 drives the output 0 and the enable 0, 01 drives the output 1, 10 drives the output 0, and 11 passes the input through. The override appears in the same cycle as the trip, with no register on the path.
- R3: Bit i of address 0 routes `trip_n[i]` into the one-shot group, and bit i of address 1 routes it into the cycle-by-cycle group. A low level on an input that is not routed to either group has no effect on the outputs or the flags.
- R4: A one-shot trip sets `ost_flag` on the next clock edge and keeps the override. Counter-zero strobes do not release either of them. Both clear only after a write of address 3 with bit 3 set.
- R5: A cycle-by-cycle trip keeps the override through a counter-zero strobe while the trip is still present. After the trip is removed, the override ends at the first clock edge where `ctr_zero` is 1, and not before.
- R6: `cbc_flag` sets on the edge after a cycle-by-cycle trip. It stays set after the override ends. It clears only after a write of address 3 with bit 2 set.
- R7: A clear command arriving while its trip is still present leaves the flag set, and the trip wins. This holds for both the one-shot flag and the cycle-by-cycle flag.
- R8: A write of address 3 with bit 1 set is a one-shot trip, and a write with bit 0 set is a cycle-by-cycle trip. Each acts on the outputs in the write cycle itself.
- R9: Address 2 bit 4 enables the cycle-by-cycle interrupt and bit 5 enables the one-shot interrupt. `irq` sets on the edge where an enabled flag goes from 0 to 1. It stays set until a write of address 3 with bit 4 set. A new set in the same cycle as that clear wins. A flag that sets while its enable is 0 leaves `irq` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_a_in | input | 1 | Raw PWM channel A |
| pwm_b_in | input | 1 | Raw PWM channel B |
| ctr_zero | input | 1 | Time-base counter at zero, one-cycle strobe |
| trip_n | input | N_TRIP | Synchronised trip inputs, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register word address |
| wr_data | input | DATA_W | Register write data |
| pwm_a_out | output | 1 | Protected channel A |
| pwm_a_oe | output | 1 | Channel A output enable (0 = high impedance) |
| pwm_b_out | output | 1 | Protected channel B |
| pwm_b_oe | output | 1 | Channel B output enable (0 = high impedance) |
| ost_flag | output | 1 | One-shot trip flag, also the one-shot override latch |
| cbc_flag | output | 1 | Cycle-by-cycle trip flag |
| irq | output | 1 | Trip interrupt, held by the global interrupt flag |

## Verification
The action stage is swept over all sixteen A/B code pairs and all four input levels, both with and without a live trip. This separates pass-through from each forced value and from high impedance on each channel. A second sweep drives each trip input low under every routing mask. It shows that only the routed inputs latch, and that the latched override outlasts the trip. Directed sequences then place counter-zero strobes, clear commands, force commands and interrupt-enable changes before, during and after a trip. These sequences separate automatic release from software release, and they show that a trip wins over a clear arriving in the same cycle.

// File: rtl/trip_guard_pkg.sv
`timescale 1ns/1ps
package trip_guard_pkg;

    localparam int unsigned N_CH = 2;

    typedef enum logic [1:0] {
        ACT_HIZ  = 2'b00,
        ACT_HIGH = 2'b01,
        ACT_LOW  = 2'b10,
        ACT_NONE = 2'b11
    } trip_act_e;

    localparam logic [1:0] ADDR_OST_SEL = 2'd0;
    localparam logic [1:0] ADDR_CBC_SEL = 2'd1;
    localparam logic [1:0] ADDR_CTRL    = 2'd2;
    localparam logic [1:0] ADDR_CMD     = 2'd3;

    localparam int unsigned CTRL_ACT_A  = 0;
    localparam int unsigned CTRL_ACT_B  = 2;
    localparam int unsigned CTRL_IE_CBC = 4;
    localparam int unsigned CTRL_IE_OST = 5;

    localparam int unsigned CMD_FRC_CBC = 0;
    localparam int unsigned CMD_FRC_OST = 1;
    localparam int unsigned CMD_CLR_CBC = 2;
    localparam int unsigned CMD_CLR_OST = 3;
    localparam int unsigned CMD_CLR_INT = 4;

    typedef struct packed {
        logic frc_cbc;
        logic frc_ost;
        logic clr_cbc;
        logic clr_ost;
        logic clr_int;
    } trip_cmd_t;

endpackage

// File: rtl/trip_cfg_regs.sv
`timescale 1ns/1ps
module trip_cfg_regs
    import trip_guard_pkg::*;
#(
    parameter int unsigned N_TRIP = 3,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [N_TRIP-1:0] ost_sel,
    output logic [N_TRIP-1:0] cbc_sel,
    output trip_act_e         act_a,
    output trip_act_e         act_b,
    output logic              ie_cbc,
    output logic              ie_ost,
    output trip_cmd_t         cmd
);

    typedef struct packed {
        logic [N_TRIP-1:0] ost_sel;
        logic [N_TRIP-1:0] cbc_sel;
        trip_act_e         act_a;
        trip_act_e         act_b;
        logic              ie_cbc;
        logic              ie_ost;
    } cfg_t;

    localparam cfg_t CFG_RST = '{
        ost_sel: '0,
        cbc_sel: '0,
        act_a:   ACT_NONE,
        act_b:   ACT_NONE,
        ie_cbc:  1'b0,
        ie_ost:  1'b0
    };

    cfg_t cfg_d, cfg_q;
    trip_cmd_t cmd_d;

    // the upper data bits are not decoded at every address
    logic unused_wr_bits;
    assign unused_wr_bits = ^wr_data;

    always_comb begin
        cfg_d = cfg_q;
        cmd_d = '0;
        if (wr_en) begin
            unique case (wr_addr)
                ADDR_OST_SEL: cfg_d.ost_sel = wr_data[N_TRIP-1:0];
                ADDR_CBC_SEL: cfg_d.cbc_sel = wr_data[N_TRIP-1:0];
                ADDR_CTRL: begin
                    cfg_d.act_a  = trip_act_e'(wr_data[CTRL_ACT_A +: 2]);
                    cfg_d.act_b  = trip_act_e'(wr_data[CTRL_ACT_B +: 2]);
                    cfg_d.ie_cbc = wr_data[CTRL_IE_CBC];
                    cfg_d.ie_ost = wr_data[CTRL_IE_OST];
                end
                ADDR_CMD: begin
                    cmd_d.frc_cbc = wr_data[CMD_FRC_CBC];
                    cmd_d.frc_ost = wr_data[CMD_FRC_OST];
                    cmd_d.clr_cbc = wr_data[CMD_CLR_CBC];
                    cmd_d.clr_ost = wr_data[CMD_CLR_OST];
                    cmd_d.clr_int = wr_data[CMD_CLR_INT];
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RST;
        else        cfg_q <= cfg_d;
    end

    assign ost_sel = cfg_q.ost_sel;
    assign cbc_sel = cfg_q.cbc_sel;
    assign act_a   = cfg_q.act_a;
    assign act_b   = cfg_q.act_b;
    assign ie_cbc  = cfg_q.ie_cbc;
    assign ie_ost  = cfg_q.ie_ost;
    assign cmd     = cmd_d;

endmodule

// File: rtl/trip_event_detect.sv
`timescale 1ns/1ps
module trip_event_detect #(
    parameter int unsigned N_TRIP = 3
) (
    input  logic [N_TRIP-1:0] trip_n,
    input  logic [N_TRIP-1:0] ost_sel,
    input  logic [N_TRIP-1:0] cbc_sel,
    input  logic              frc_ost,
    input  logic              frc_cbc,
    output logic              ost_evt,
    output logic              cbc_evt
);

    logic [N_TRIP-1:0] asserted;
    logic [N_TRIP-1:0] ost_hits;
    logic [N_TRIP-1:0] cbc_hits;

    for (genvar i = 0; i < N_TRIP; i++) begin : g_in
        assign asserted[i] = ~trip_n[i];
        assign ost_hits[i] = asserted[i] & ost_sel[i];
        assign cbc_hits[i] = asserted[i] & cbc_sel[i];
    end

    always_comb begin
        ost_evt = frc_ost | (|ost_hits);
        cbc_evt = frc_cbc | (|cbc_hits);
    end

endmodule

// File: rtl/trip_latch_ctrl.sv
`timescale 1ns/1ps
module trip_latch_ctrl
    import trip_guard_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ost_evt,
    input  logic      cbc_evt,
    input  logic      ctr_zero,
    input  logic      ie_cbc,
    input  logic      ie_ost,
    input  trip_cmd_t cmd,
    output logic      ost_flag,
    output logic      cbc_flag,
    output logic      irq_flag,
    output logic      trip_active
);

    typedef struct packed {
        logic ost;
        logic cbc_hold;
        logic cbc_flag;
        logic irq;
    } latch_t;

    latch_t st_d, st_q;
    logic irq_set;

    always_comb begin
        st_d = st_q;
        // one-shot: only software releases it, a live trip wins over the clear
        st_d.ost      = ost_evt | (st_q.ost & ~cmd.clr_ost);
        // cycle-by-cycle override: released at counter zero once the trip is gone
        st_d.cbc_hold = cbc_evt | (st_q.cbc_hold & ~ctr_zero);
        st_d.cbc_flag = cbc_evt | (st_q.cbc_flag & ~cmd.clr_cbc);
        irq_set       = (ie_cbc & cbc_evt & ~st_q.cbc_flag)
                      | (ie_ost & ost_evt & ~st_q.ost);
        st_d.irq      = irq_set | (st_q.irq & ~cmd.clr_int);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ost_flag    = st_q.ost;
    assign cbc_flag    = st_q.cbc_flag;
    assign irq_flag    = st_q.irq;
    assign trip_active = ost_evt | cbc_evt | st_q.ost | st_q.cbc_hold;

    a_r4_ost_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ost && !cmd.clr_ost) |=> st_q.ost);

    a_r5_hold_until_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cbc_hold && !ctr_zero) |=> st_q.cbc_hold);

    a_r6_cbc_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cbc_flag && !cmd.clr_cbc) |=> st_q.cbc_flag);

    a_r7_cbc_trip_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cbc_evt |=> (st_q.cbc_flag && st_q.cbc_hold));

    a_r7_ost_trip_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ost_evt |=> st_q.ost);

    a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.irq && !cmd.clr_int) |=> st_q.irq);

    a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie_cbc && !ie_ost && !st_q.irq) |=> !st_q.irq);

endmodule

// File: rtl/trip_output_stage.sv
`timescale 1ns/1ps
module trip_output_stage
    import trip_guard_pkg::*;
(
    input  logic                 trip_active,
    input  logic [N_CH-1:0]      pwm_in,
    input  logic [N_CH-1:0][1:0] act_code,
    output logic [N_CH-1:0]      pwm_out,
    output logic [N_CH-1:0]      pwm_oe
);

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic out_c;
        logic oe_c;

        always_comb begin
            out_c = pwm_in[c];
            oe_c  = 1'b1;
            if (trip_active) begin
                unique case (trip_act_e'(act_code[c]))
                    ACT_HIZ: begin
                        out_c = 1'b0;
                        oe_c  = 1'b0;
                    end
                    ACT_HIGH: out_c = 1'b1;
                    ACT_LOW:  out_c = 1'b0;
                    ACT_NONE: out_c = pwm_in[c];
                endcase
            end
        end

        assign pwm_out[c] = out_c;
        assign pwm_oe[c]  = oe_c;
    end

endmodule

// File: rtl/pwm_trip_guard.sv
`timescale 1ns/1ps
module pwm_trip_guard
    import trip_guard_pkg::*;
#(
    parameter int unsigned N_TRIP = 3,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwm_a_in,
    input  logic              pwm_b_in,
    input  logic              ctr_zero,
    input  logic [N_TRIP-1:0] trip_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pwm_a_out,
    output logic              pwm_a_oe,
    output logic              pwm_b_out,
    output logic              pwm_b_oe,
    output logic              ost_flag,
    output logic              cbc_flag,
    output logic              irq
);

    logic [N_TRIP-1:0] ost_sel;
    logic [N_TRIP-1:0] cbc_sel;
    trip_act_e         act_a;
    trip_act_e         act_b;
    logic              ie_cbc;
    logic              ie_ost;
    trip_cmd_t         cmd;
    logic              ost_evt;
    logic              cbc_evt;
    logic              trip_active;
    logic              irq_flag;

    logic [N_CH-1:0]      ch_in;
    logic [N_CH-1:0]      ch_out;
    logic [N_CH-1:0]      ch_oe;
    logic [N_CH-1:0][1:0] ch_act;

    trip_cfg_regs #(.N_TRIP(N_TRIP), .DATA_W(DATA_W)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ost_sel (ost_sel),
        .cbc_sel (cbc_sel),
        .act_a   (act_a),
        .act_b   (act_b),
        .ie_cbc  (ie_cbc),
        .ie_ost  (ie_ost),
        .cmd     (cmd)
    );

    trip_event_detect #(.N_TRIP(N_TRIP)) i_detect (
        .trip_n  (trip_n),
        .ost_sel (ost_sel),
        .cbc_sel (cbc_sel),
        .frc_ost (cmd.frc_ost),
        .frc_cbc (cmd.frc_cbc),
        .ost_evt (ost_evt),
        .cbc_evt (cbc_evt)
    );

    trip_latch_ctrl i_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .ost_evt     (ost_evt),
        .cbc_evt     (cbc_evt),
        .ctr_zero    (ctr_zero),
        .ie_cbc      (ie_cbc),
        .ie_ost      (ie_ost),
        .cmd         (cmd),
        .ost_flag    (ost_flag),
        .cbc_flag    (cbc_flag),
        .irq_flag    (irq_flag),
        .trip_active (trip_active)
    );

    assign ch_in  = {pwm_b_in, pwm_a_in};
    assign ch_act = {act_b, act_a};

    trip_output_stage i_out (
        .trip_active (trip_active),
        .pwm_in      (ch_in),
        .act_code    (ch_act),
        .pwm_out     (ch_out),
        .pwm_oe      (ch_oe)
    );

    assign pwm_a_out = ch_out[0];
    assign pwm_b_out = ch_out[1];
    assign pwm_a_oe  = ch_oe[0];
    assign pwm_b_oe  = ch_oe[1];
    assign irq       = irq_flag;

    a_r2_a_low: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_active && act_a == ACT_LOW) |-> (!pwm_a_out && pwm_a_oe));

    a_r2_b_high: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_active && act_b == ACT_HIGH) |-> (pwm_b_out && pwm_b_oe));

    a_r2_hiz_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_a_oe || !pwm_b_oe) |-> trip_active);

    a_r3_quiet_passes: assert property (@(posedge clk) disable iff (!rst_n)
        !trip_active |-> (pwm_a_out == pwm_a_in && pwm_b_out == pwm_b_in
                          && pwm_a_oe && pwm_b_oe));

endmodule

// File: tb/test_pwm_trip_guard.sv
`timescale 1ns/1ps
module test_pwm_trip_guard;

    localparam int N_TRIP = 3;
    localparam logic [3:0] PASS   = 4'b1101; // a=1 oe=1, b=0 oe=1
    localparam logic [3:0] FORCED = 4'b0111; // A code 10 -> 0, B code 01 -> 1

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_a_in = 1'b1, pwm_b_in = 1'b0, ctr_zero = 1'b0;
    logic [N_TRIP-1:0] trip_n = '1;
    logic wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic pwm_a_out, pwm_a_oe, pwm_b_out, pwm_b_oe, ost_flag, cbc_flag, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwm_trip_guard #(.N_TRIP(N_TRIP), .DATA_W(16)) i_pwm_trip_guard (
        .clk, .rst_n, .pwm_a_in, .pwm_b_in, .ctr_zero, .trip_n,
        .wr_en, .wr_addr, .wr_data,
        .pwm_a_out, .pwm_a_oe, .pwm_b_out, .pwm_b_oe,
        .ost_flag, .cbc_flag, .irq
    );

    function automatic logic [3:0] obs();
        return {pwm_a_out, pwm_a_oe, pwm_b_out, pwm_b_oe};
    endfunction

    // {out, oe} of one channel under a code
    function automatic logic [1:0] exp_ch(input logic [1:0] code, input logic din,
                                          input logic active);
        if (!active || code == 2'b11) return {din, 1'b1};
        case (code)
            2'b00:   return 2'b00;
            2'b01:   return 2'b11;
            default: return 2'b01;
        endcase
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        #0.5;
    endtask

    task automatic zero_pulse();
        @(negedge clk); ctr_zero = 1'b1;
        @(negedge clk); ctr_zero = 1'b0;
        #0.5;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        // R1 reset state
        chk("R1 outputs", obs(), PASS);
        chk("R1 flags", {ost_flag, cbc_flag, irq}, 3'b000);
        @(negedge clk); trip_n = 3'b000; #0.5;
        chk("R1 default code passes", obs(), PASS);
        trip_n = '1;

        // R2 sweep: every code pair, every input level, trip via input 0 in cbc group
        wr(2'd1, 16'h0001);
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                wr(2'd2, 16'((b << 2) | a));
                for (int p = 0; p < 4; p++) begin
                    @(negedge clk);
                    pwm_a_in = p[0]; pwm_b_in = p[1]; trip_n = '1;
                    #0.5;
                    chk("R2 idle", obs(), {exp_ch(2'(a), p[0], 1'b0), exp_ch(2'(b), p[1], 1'b0)});
                    trip_n[0] = 1'b0;
                    #0.5;
                    chk("R2 tripped", obs(), {exp_ch(2'(a), p[0], 1'b1), exp_ch(2'(b), p[1], 1'b1)});
                    trip_n = '1;
                end
            end
        end
        @(negedge clk); pwm_a_in = 1'b1; pwm_b_in = 1'b0;
        wr(2'd2, 16'h0006);
        wr(2'd1, 16'h0000);
        chk("R2 no latch from sweep", {ost_flag, cbc_flag, irq}, 3'b000);

        // R3 routing sweep
        for (int i = 0; i < N_TRIP; i++) begin
            for (int m = 0; m < 8; m++) begin
                wr(2'd0, 16'(m));
                @(negedge clk); trip_n = ~(3'b001 << i); #0.5;
                chk("R3 immediate", obs(), m[i] ? FORCED : PASS);
                @(negedge clk); trip_n = '1; #0.5;
                chk("R3 flag", ost_flag, m[i]);
                chk("R3 latched", obs(), m[i] ? FORCED : PASS);
                wr(2'd3, 16'h0008);
                chk("R3 cleared", {ost_flag, obs()}, {1'b0, PASS});
            end
        end

        // R4 one-shot survives counter zero
        wr(2'd0, 16'h0001);
        @(negedge clk); trip_n = 3'b110;
        @(negedge clk); trip_n = 3'b111;
        zero_pulse(); zero_pulse();
        chk("R4 held through zero", {ost_flag, obs()}, {1'b1, FORCED});
        wr(2'd3, 16'h0008);
        chk("R4 released by clear", {ost_flag, obs()}, {1'b0, PASS});

        // R5 / R6 cycle-by-cycle release
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h0002);
        @(negedge clk); trip_n = 3'b101; #0.5;
        chk("R5 same cycle", obs(), FORCED);
        zero_pulse();
        chk("R5 zero with trip present", obs(), FORCED);
        trip_n = 3'b111; #0.5;
        chk("R5 hold after trip gone", obs(), FORCED);
        repeat (3) @(negedge clk); #0.5;
        chk("R5 no release without zero", obs(), FORCED);
        @(negedge clk); ctr_zero = 1'b1; #0.5;
        chk("R5 before zero edge", obs(), FORCED);
        @(negedge clk); ctr_zero = 1'b0; #0.5;
        chk("R5 released at zero", obs(), PASS);
        chk("R6 flag survives release", cbc_flag, 1'b1);
        repeat (2) @(negedge clk); #0.5;
        chk("R6 flag still set", cbc_flag, 1'b1);
        wr(2'd3, 16'h0004);
        chk("R6 flag cleared", cbc_flag, 1'b0);

        // R7 trip beats clear
        @(negedge clk); trip_n = 3'b101;
        wr(2'd3, 16'h0004);
        chk("R7 cbc flag kept", cbc_flag, 1'b1);
        @(negedge clk); trip_n = 3'b111;
        zero_pulse();
        wr(2'd3, 16'h0004);
        chk("R7 cbc cleared later", {cbc_flag, obs()}, {1'b0, PASS});
        wr(2'd1, 16'h0000);
        wr(2'd0, 16'h0001);
        @(negedge clk); trip_n = 3'b110;
        wr(2'd3, 16'h0008);
        chk("R7 ost flag kept", {ost_flag, obs()}, {1'b1, FORCED});
        @(negedge clk); trip_n = 3'b111;
        wr(2'd3, 16'h0008);
        chk("R7 ost cleared later", {ost_flag, obs()}, {1'b0, PASS});

        // R8 software forces
        wr(2'd0, 16'h0000);
        @(negedge clk); wr_en = 1'b1; wr_addr = 2'd3; wr_data = 16'h0002; #0.5;
        chk("R8 ost force same cycle", obs(), FORCED);
        @(negedge clk); wr_en = 1'b0; #0.5;
        chk("R8 ost force latched", {ost_flag, obs()}, {1'b1, FORCED});
        wr(2'd3, 16'h0008);
        chk("R8 ost force cleared", {ost_flag, obs()}, {1'b0, PASS});
        @(negedge clk); wr_en = 1'b1; wr_addr = 2'd3; wr_data = 16'h0001; #0.5;
        chk("R8 cbc force same cycle", obs(), FORCED);
        @(negedge clk); wr_en = 1'b0; #0.5;
        chk("R8 cbc force held", {cbc_flag, obs()}, {1'b1, FORCED});
        zero_pulse();
        chk("R8 cbc force released at zero", obs(), PASS);
        chk("R9 no irq while disabled", irq, 1'b0);
        wr(2'd3, 16'h0004);

        // R9 interrupt
        wr(2'd2, 16'h0026);
        wr(2'd3, 16'h0002);
        chk("R9 ost irq", {irq, ost_flag}, 2'b11);
        wr(2'd3, 16'h0010);
        chk("R9 irq cleared, flag stays", {irq, ost_flag}, 2'b01);
        wr(2'd3, 16'h0008);
        chk("R9 no retrigger", {irq, ost_flag}, 2'b00);
        wr(2'd2, 16'h0016);
        wr(2'd3, 16'h0011);
        chk("R9 set wins over clear", {irq, cbc_flag}, 2'b11);
        zero_pulse();
        wr(2'd3, 16'h0014);
        chk("R9 both cleared", {irq, cbc_flag}, 2'b00);
        wr(2'd3, 16'h0002);
        chk("R9 ost masked", {irq, ost_flag}, 2'b01);
        wr(2'd3, 16'h0008);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule